// File: doc/BRIEF.md
# Poison-Tagged Register File

This block is a general-purpose register file in which every entry carries one extra bit, the poison tag. A speculative load that would have faulted does not trap. It writes its destination with a zero value and sets the tag. ALU results take the OR of their two source tags. A fault therefore follows every value that depends on it, and one check on the last register of a dependent chain is enough to decide whether recovery code must run. The recovery code re-executes the whole chain and is outside this block.

There are three write sources: an ALU result port that carries its source tags, a speculative-load writeback port that carries a fault flag, and a check-request port. There are three read paths: two operand read ports and one internal read for the check. Every read path forwards a write to the same register in the same cycle. A check request is answered on the next cycle by a small state machine.

- CK_IDLE: no response is pending.
- CK_FALLTHRU: the checked tag was clear.
- CK_RECOVER: the checked tag was set, so control must redirect.

From any state, a request moves the machine to CK_RECOVER or CK_FALLTHRU according to the checked tag. The absence of a request moves it to CK_IDLE.

Top module: `ptag_regfile`

## Requirements
- R1: After reset every register reads value 0 with its tag clear, and chk_valid, chk_redirect and chk_addr are 0.
- R2: Register 0 always reads value 0 with its tag clear. Writes to it from either port have no effect.
- R3: An ALU write stores alu_data and sets the destination tag to alu_src_poison_a OR alu_src_poison_b.
- R4: A load write with ld_fault=1 raises no exception. It stores value 0 and sets the destination tag.
- R5: A load write with ld_fault=0 stores ld_data and clears the tag. An ALU write whose two source tags are both clear also clears the tag.
- R6: A read of a register that is being written in the same cycle returns the new value and the new tag, on both read ports.
- R7: When the load port and the ALU port write the same register in the same cycle, the load write takes effect and the ALU write is dropped.
- R8: chk_valid is 1 exactly one cycle after each cycle with chk_req=1. In that cycle chk_redirect equals the tag of register chk_idx, and chk_addr equals the chk_target given with the request.
- R9: A fault set by a load reaches the end of a chain of dependent ALU writes. A check on the final register of the chain redirects, and a check on an untainted register falls through.
- R10: A check on a register that is being written in the same cycle uses the tag of that write.
- R11: In a cycle that follows a cycle without chk_req, chk_valid, chk_redirect and chk_addr are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_idx | input | 5 | Read port A register index |
| rd_b_idx | input | 5 | Read port B register index |
| rd_a_data | output | 64 | Read port A value |
| rd_a_poison | output | 1 | Read port A tag |
| rd_b_data | output | 64 | Read port B value |
| rd_b_poison | output | 1 | Read port B tag |
| alu_we | input | 1 | ALU result write enable |
| alu_dst | input | 5 | ALU destination register |
| alu_data | input | 64 | ALU result value |
| alu_src_poison_a | input | 1 | Tag of first ALU source |
| alu_src_poison_b | input | 1 | Tag of second ALU source |
| ld_we | input | 1 | Speculative load writeback enable |
| ld_dst | input | 5 | Load destination register |
| ld_data | input | 64 | Loaded value |
| ld_fault | input | 1 | The load would have faulted |
| chk_req | input | 1 | Check request |
| chk_idx | input | 5 | Register to check |
| chk_target | input | 64 | Recovery address supplied with the check |
| chk_valid | output | 1 | Check response present |
| chk_redirect | output | 1 | Redirect to recovery code is required |
| chk_addr | output | 64 | Recovery address of the answered check |

## Verification
The tag logic is exercised with ALU writes for each of the four source-tag combinations, which separates a true OR from an AND, from a pass-through of one source, and from a tag that never clears. Faulting and clean loads to the same register show that a clean write clears the tag and that a faulted value is zeroed. A three-step dependent chain with checks at its end and on a clean register shows that inheritance and the redirect decision line up. Collisions are also driven: write-and-read in the same cycle, both write ports on one register, and a check on a register being written. A long pseudo-random phase with a behavioural model compared on every clock covers back-to-back and idle check sequences.

// File: rtl/ptag_pkg.sv
package ptag_pkg;

    typedef enum logic [1:0] {
        CK_IDLE     = 2'd0,
        CK_FALLTHRU = 2'd1,
        CK_RECOVER  = 2'd2
    } chk_state_e;

    // A result is poisoned when any operand it came from is poisoned.
    function automatic logic poison_merge(input logic a, input logic b);
        return a | b;
    endfunction

endpackage

// File: rtl/ptag_store.sv
module ptag_store #(
    parameter int DATA_W   = 64,
    parameter int NUM_REGS = 32,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_dst,
    input  logic [DATA_W-1:0] ld_val,
    input  logic              ld_tag,
    input  logic              al_en,
    input  logic [ADDR_W-1:0] al_dst,
    input  logic [DATA_W-1:0] al_val,
    input  logic              al_tag,
    output logic [DATA_W-1:0] mem_val [NUM_REGS],
    output logic [NUM_REGS-1:0] mem_tag
);

    assign mem_val[0] = '0;
    assign mem_tag[0] = 1'b0;

    for (genvar r = 1; r < NUM_REGS; r++) begin : g_entry
        logic hit_ld;
        logic hit_al;
        assign hit_ld = ld_en && (ld_dst == ADDR_W'(r));
        assign hit_al = al_en && (al_dst == ADDR_W'(r));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_val[r] <= '0;
                mem_tag[r] <= 1'b0;
            end else if (hit_ld) begin
                mem_val[r] <= ld_val;
                mem_tag[r] <= ld_tag;
            end else if (hit_al) begin
                mem_val[r] <= al_val;
                mem_tag[r] <= al_tag;
            end
        end
    end

endmodule

// File: rtl/ptag_read_port.sv
module ptag_read_port #(
    parameter int DATA_W   = 64,
    parameter int NUM_REGS = 32,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic [ADDR_W-1:0]   idx,
    input  logic [DATA_W-1:0]   mem_val [NUM_REGS],
    input  logic [NUM_REGS-1:0] mem_tag,
    input  logic                ld_en,
    input  logic [ADDR_W-1:0]   ld_dst,
    input  logic [DATA_W-1:0]   ld_val,
    input  logic                ld_tag,
    input  logic                al_en,
    input  logic [ADDR_W-1:0]   al_dst,
    input  logic [DATA_W-1:0]   al_val,
    input  logic                al_tag,
    output logic [DATA_W-1:0]   val,
    output logic                tag
);

    always_comb begin
        if (idx == '0) begin
            val = '0;
            tag = 1'b0;
        end else if (ld_en && ld_dst == idx) begin
            val = ld_val;
            tag = ld_tag;
        end else if (al_en && al_dst == idx) begin
            val = al_val;
            tag = al_tag;
        end else begin
            val = mem_val[idx];
            tag = mem_tag[idx];
        end
    end

endmodule

// File: rtl/ptag_check_fsm.sv
module ptag_check_fsm
    import ptag_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              tag,
    input  logic [DATA_W-1:0] target,
    output logic              valid,
    output logic              redirect,
    output logic [DATA_W-1:0] addr
);

    chk_state_e        state_q, state_d;
    logic [DATA_W-1:0] target_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= CK_IDLE;
            target_q <= '0;
        end else begin
            state_q  <= state_d;
            if (req) target_q <= target;
        end
    end

    always_comb begin
        state_d = CK_IDLE;
        unique case (state_q)
            CK_IDLE, CK_FALLTHRU, CK_RECOVER: begin
                if (req) state_d = tag ? CK_RECOVER : CK_FALLTHRU;
                else     state_d = CK_IDLE;
            end
            default: state_d = CK_IDLE;
        endcase
    end

    always_comb begin
        valid    = 1'b0;
        redirect = 1'b0;
        addr     = '0;
        unique case (state_q)
            CK_IDLE: ;
            CK_FALLTHRU: begin
                valid = 1'b1;
                addr  = target_q;
            end
            CK_RECOVER: begin
                valid    = 1'b1;
                redirect = 1'b1;
                addr     = target_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ptag_regfile.sv
module ptag_regfile
    import ptag_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NUM_REGS = 32,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_a_idx,
    input  logic [ADDR_W-1:0] rd_b_idx,
    output logic [DATA_W-1:0] rd_a_data,
    output logic              rd_a_poison,
    output logic [DATA_W-1:0] rd_b_data,
    output logic              rd_b_poison,
    input  logic              alu_we,
    input  logic [ADDR_W-1:0] alu_dst,
    input  logic [DATA_W-1:0] alu_data,
    input  logic              alu_src_poison_a,
    input  logic              alu_src_poison_b,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_dst,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              ld_fault,
    input  logic              chk_req,
    input  logic [ADDR_W-1:0] chk_idx,
    input  logic [DATA_W-1:0] chk_target,
    output logic              chk_valid,
    output logic              chk_redirect,
    output logic [DATA_W-1:0] chk_addr
);

    localparam int NUM_RD = 3;   // port A, port B, check lookup

    // Resolved write sources
    logic              ld_en, al_en, ld_tag, al_tag;
    logic [DATA_W-1:0] ld_val;

    assign ld_en  = ld_we;
    assign ld_tag = ld_fault;
    assign ld_val = ld_fault ? '0 : ld_data;
    assign al_en  = alu_we && !(ld_we && ld_dst == alu_dst);
    assign al_tag = poison_merge(alu_src_poison_a, alu_src_poison_b);

    logic [DATA_W-1:0]   mem_val [NUM_REGS];
    logic [NUM_REGS-1:0] mem_tag;

    ptag_store #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_en  (ld_en),
        .ld_dst (ld_dst),
        .ld_val (ld_val),
        .ld_tag (ld_tag),
        .al_en  (al_en),
        .al_dst (alu_dst),
        .al_val (alu_data),
        .al_tag (al_tag),
        .mem_val(mem_val),
        .mem_tag(mem_tag)
    );

    logic [ADDR_W-1:0] rp_idx [NUM_RD];
    logic [DATA_W-1:0] rp_val [NUM_RD];
    logic [NUM_RD-1:0] rp_tag;

    assign rp_idx[0] = rd_a_idx;
    assign rp_idx[1] = rd_b_idx;
    assign rp_idx[2] = chk_idx;

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        ptag_read_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rp (
            .idx    (rp_idx[p]),
            .mem_val(mem_val),
            .mem_tag(mem_tag),
            .ld_en  (ld_en),
            .ld_dst (ld_dst),
            .ld_val (ld_val),
            .ld_tag (ld_tag),
            .al_en  (al_en),
            .al_dst (alu_dst),
            .al_val (alu_data),
            .al_tag (al_tag),
            .val    (rp_val[p]),
            .tag    (rp_tag[p])
        );
    end

    assign rd_a_data   = rp_val[0];
    assign rd_a_poison = rp_tag[0];
    assign rd_b_data   = rp_val[1];
    assign rd_b_poison = rp_tag[1];

    // The check-lookup value path (rp_val[2]) is produced by the shared slice but not consumed.
    logic unused_chk_val;
    assign unused_chk_val = ^rp_val[2];

    ptag_check_fsm #(.DATA_W(DATA_W)) u_chk_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (chk_req),
        .tag     (rp_tag[2]),
        .target  (chk_target),
        .valid   (chk_valid),
        .redirect(chk_redirect),
        .addr    (chk_addr)
    );

endmodule

// File: rtl/ptag_regfile_chk.sv
module ptag_regfile_chk #(
    parameter int DATA_W   = 64,
    parameter int NUM_REGS = 32,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] rd_a_idx,
    input logic [ADDR_W-1:0] rd_b_idx,
    input logic [DATA_W-1:0] rd_a_data,
    input logic              rd_a_poison,
    input logic [DATA_W-1:0] rd_b_data,
    input logic              rd_b_poison,
    input logic              alu_we,
    input logic [ADDR_W-1:0] alu_dst,
    input logic [DATA_W-1:0] alu_data,
    input logic              alu_src_poison_a,
    input logic              alu_src_poison_b,
    input logic              ld_we,
    input logic [ADDR_W-1:0] ld_dst,
    input logic [DATA_W-1:0] ld_data,
    input logic              ld_fault,
    input logic              chk_req,
    input logic [ADDR_W-1:0] chk_idx,
    input logic [DATA_W-1:0] chk_target,
    input logic              chk_valid,
    input logic              chk_redirect,
    input logic [DATA_W-1:0] chk_addr
);

    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    logic a_untouched;
    assign a_untouched = !(ld_we && ld_dst == rd_a_idx) && !(alu_we && alu_dst == rd_a_idx);

    assert_zero_reg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == '0) |-> (rd_a_data == '0 && !rd_a_poison));

    assert_chk_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        chk_req |=> chk_valid);

    assert_chk_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
        chk_req |=> (chk_addr == $past(chk_target)));

    assert_chk_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_req |=> (!chk_valid && !chk_redirect && chk_addr == '0));

    assert_fault_sticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(ld_we && ld_fault && ld_dst != '0) &&
         rd_a_idx == $past(ld_dst) && a_untouched)
        |-> (rd_a_poison && rd_a_data == '0));

    assert_alu_merge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(alu_we && alu_dst != '0 && !(ld_we && ld_dst == alu_dst)) &&
         rd_a_idx == $past(alu_dst) && a_untouched)
        |-> (rd_a_data == $past(alu_data) &&
             rd_a_poison == $past(alu_src_poison_a || alu_src_poison_b)));

    assert_fwd_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_we && ld_dst != '0 && rd_b_idx == ld_dst) |-> (rd_b_poison == ld_fault));

endmodule

bind ptag_regfile ptag_regfile_chk u_ptag_chk (.*);

// File: tb/ptag_regfile_test.sv
module ptag_regfile_test;

    localparam int DW = 64;
    localparam int NR = 32;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] rd_a_idx = '0, rd_b_idx = '0;
    logic [DW-1:0] rd_a_data, rd_b_data;
    logic          rd_a_poison, rd_b_poison;
    logic          alu_we = 0;
    logic [AW-1:0] alu_dst = '0;
    logic [DW-1:0] alu_data = '0;
    logic          alu_src_poison_a = 0, alu_src_poison_b = 0;
    logic          ld_we = 0;
    logic [AW-1:0] ld_dst = '0;
    logic [DW-1:0] ld_data = '0;
    logic          ld_fault = 0;
    logic          chk_req = 0;
    logic [AW-1:0] chk_idx = '0;
    logic [DW-1:0] chk_target = '0;
    logic          chk_valid, chk_redirect;
    logic [DW-1:0] chk_addr;

    ptag_regfile uut (.*);

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Behavioural reference state
    logic [DW-1:0] m_val [NR];
    logic          m_tag [NR];
    logic          e_valid = 0, e_redir = 0;
    logic [DW-1:0] e_addr = '0;

    task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp,
                         input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic void model_read(input logic [AW-1:0] idx,
                                       output logic [DW-1:0] v, output logic t);
        if (idx == 0) begin
            v = '0; t = 1'b0;
        end else if (ld_we && ld_dst == idx) begin
            v = ld_fault ? '0 : ld_data; t = ld_fault;
        end else if (alu_we && alu_dst == idx) begin
            v = alu_data; t = alu_src_poison_a | alu_src_poison_b;
        end else begin
            v = m_val[idx]; t = m_tag[idx];
        end
    endfunction

    task automatic idle_inputs();
        alu_we = 0; ld_we = 0; chk_req = 0;
        alu_src_poison_a = 0; alu_src_poison_b = 0; ld_fault = 0;
    endtask

    // Called just after a falling edge with inputs driven; returns after the next falling edge.
    task automatic cycle(input string req);
        logic [DW-1:0] v;
        logic t;
        #1;
        check(chk_valid, DW'(e_valid), req, "chk_valid");
        check(chk_redirect, DW'(e_redir), req, "chk_redirect");
        check(chk_addr, e_addr, req, "chk_addr");
        model_read(rd_a_idx, v, t);
        check(rd_a_data, v, req, "rd_a_data");
        check(DW'(rd_a_poison), DW'(t), req, "rd_a_poison");
        model_read(rd_b_idx, v, t);
        check(rd_b_data, v, req, "rd_b_data");
        check(DW'(rd_b_poison), DW'(t), req, "rd_b_poison");
        if (chk_req) begin
            model_read(chk_idx, v, t);
            e_valid = 1; e_redir = t; e_addr = chk_target;
        end else begin
            e_valid = 0; e_redir = 0; e_addr = '0;
        end
        if (ld_we && ld_dst != 0) begin
            m_val[ld_dst] = ld_fault ? '0 : ld_data;
            m_tag[ld_dst] = ld_fault;
        end
        if (alu_we && alu_dst != 0 && !(ld_we && ld_dst == alu_dst)) begin
            m_val[alu_dst] = alu_data;
            m_tag[alu_dst] = alu_src_poison_a | alu_src_poison_b;
        end
        @(negedge clk);
    endtask

    task automatic alu_wr(input int dst, input logic [DW-1:0] d, input logic pa, input logic pb);
        alu_we = 1; alu_dst = AW'(dst); alu_data = d;
        alu_src_poison_a = pa; alu_src_poison_b = pb;
    endtask

    task automatic ld_wr(input int dst, input logic [DW-1:0] d, input logic f);
        ld_we = 1; ld_dst = AW'(dst); ld_data = d; ld_fault = f;
    endtask

    task automatic read_ab(input int a, input int b);
        rd_a_idx = AW'(a); rd_b_idx = AW'(b);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NR; i++) begin m_val[i] = '0; m_tag[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: every register clear after reset
        for (int i = 0; i < NR; i += 2) begin
            read_ab(i, i + 1);
            cycle("R1");
        end

        // R2: writes to register 0 ignored
        alu_wr(0, 64'hFFFF_0000_1111_2222, 1, 1); read_ab(0, 0); cycle("R2");
        idle_inputs(); ld_wr(0, 64'h55, 1); cycle("R2");
        idle_inputs(); read_ab(0, 0); cycle("R2");

        // R3: all four source-tag combinations
        alu_wr(5, 64'h1234, 1, 0); cycle("R3");
        alu_wr(6, 64'h5678, 0, 0); cycle("R3");
        alu_wr(7, 64'h9ABC, 0, 1); cycle("R3");
        alu_wr(3, 64'hDEF0, 1, 1); cycle("R3");
        idle_inputs(); read_ab(5, 6); cycle("R3");
        read_ab(7, 3); cycle("R3");

        // R4: faulting load zeroes value and sets tag
        ld_wr(8, 64'hDEAD_BEEF, 1); cycle("R4");
        idle_inputs(); read_ab(8, 8); cycle("R4");

        // R5: clean writes clear tags
        ld_wr(8, 64'hCAFE, 0); cycle("R5");
        idle_inputs(); alu_wr(5, 64'h77, 0, 0); cycle("R5");
        idle_inputs(); read_ab(8, 5); cycle("R5");

        // R6: same-cycle forwarding on both ports
        alu_wr(9, 64'h9999, 0, 1); read_ab(9, 9); cycle("R6");
        idle_inputs(); ld_wr(9, 64'hAAAA, 1); read_ab(9, 9); cycle("R6");
        idle_inputs(); ld_wr(9, 64'hBBBB, 0); read_ab(2, 9); cycle("R6");

        // R7: both ports on one register, load wins
        idle_inputs(); ld_wr(10, 64'h1010, 0); alu_wr(10, 64'h2020, 1, 1);
        read_ab(10, 4); cycle("R7");
        idle_inputs(); read_ab(10, 10); cycle("R7");

        // R9: fault travels down r11 -> r12 -> r13, checks at the end
        idle_inputs(); ld_wr(11, 64'h11, 1); cycle("R9");
        idle_inputs(); read_ab(11, 6); #1;
        alu_wr(12, 64'h12, rd_a_poison, rd_b_poison); cycle("R9");
        idle_inputs(); read_ab(6, 12); #1;
        alu_wr(13, 64'h13, rd_a_poison, rd_b_poison); cycle("R9");
        idle_inputs(); chk_req = 1; chk_idx = 13; chk_target = 64'h400; cycle("R9");
        chk_req = 1; chk_idx = 6; chk_target = 64'h800; cycle("R9");
        idle_inputs(); cycle("R8");

        // R10: check sees a same-cycle write
        ld_wr(14, 64'h14, 1); chk_req = 1; chk_idx = 14; chk_target = 64'hC00; cycle("R10");
        idle_inputs(); alu_wr(14, 64'h15, 0, 0); chk_req = 1; chk_idx = 14;
        chk_target = 64'hD00; cycle("R10");

        // R11: idle after back-to-back checks
        idle_inputs(); chk_req = 1; chk_idx = 3; chk_target = 64'hE00; cycle("R8");
        idle_inputs(); cycle("R11");
        cycle("R11");

        // Pseudo-random mix
        for (int n = 0; n < 600; n++) begin
            alu_we = 1'($urandom); alu_dst = AW'($urandom);
            alu_data = {$urandom, $urandom};
            alu_src_poison_a = ($urandom % 4) == 0; alu_src_poison_b = ($urandom % 4) == 0;
            ld_we = 1'($urandom); ld_dst = AW'($urandom);
            ld_data = {$urandom, $urandom}; ld_fault = ($urandom % 3) == 0;
            chk_req = 1'($urandom); chk_idx = AW'($urandom);
            chk_target = {$urandom, $urandom};
            rd_a_idx = AW'($urandom); rd_b_idx = AW'($urandom);
            cycle("R3");
        end

        idle_inputs(); cycle("R11");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule